// File: doc/BRIEF.md
# Drive Link Host Nibble Controller

This block sits on the host side of a narrow handshaked link to an optical drive controller. Data crosses the link four bits at a time. The drive announces a status frame by pulling its ready request low. The host then raises its acknowledge/clock line, and the drive places a nibble on the bus and pulses its strobe. Ten nibbles make one frame, and the host stores them in ten read-only status registers. In the other direction, host software fills ten command registers. Writing the last of them launches a ten-nibble transmission under the same acknowledge/strobe handshake.

The host writes the command registers through a two-lane port with one lane enable per lane. Each write addresses a pair of registers. The host reads status and command registers through one read select. An enable input gates the whole link. When it is low, the link is idle and every request is dropped. Its rising edge raises an interrupt at once. A status frame also raises an interrupt when its eighth nibble lands, so the handler can start before the frame is complete. Two busy flags report reception and transmission in progress. Every wait for the drive strobe ends after a programmable number of cycles, and the link then returns to idle.

Top module: `nib_link_host`

## Requirements
- R1: After reset, every status and command register reads 0. `host_ack`, `rx_busy`, `tx_busy`, `irq` and `drv_dout` are 0.
- R2: Writes through the command port never change a status register. Only received nibbles do. Read select values 0..9 return status nibbles 0..9, and 10..19 return command nibbles 0..9.
- R3: A write to pair p with `wr_be[1]` set stores `wr_data[7:4]` into command nibble 2p. With `wr_be[0]` set it stores `wr_data[3:0]` into nibble 2p+1. Pair values 5..7 change nothing.
- R4: While enabled, a falling edge on `drv_ready_n` raises `host_ack` two cycles later. Each strobe seen with `host_ack` high stores `drv_din` into the next status register, in order 0..9. `host_ack` then drops for exactly one cycle before it rises for the next nibble.
- R5: `rx_busy` rises in the cycle after the first status nibble is stored. It falls in the cycle after the tenth.
- R6: `irq` pulses high for one cycle in the cycle after the eighth status nibble is stored. It stays low after the other nine.
- R7: A write that covers only command nibble 8 (pair 4, lane 1) starts no transmission.
- R8: A write that covers command nibble 9 (pair 4, lane 0) sets `tx_busy` in the next cycle. Two cycles after the write, `host_ack` rises with `drv_dout` equal to command nibble 0. Each strobe advances to the next nibble, and `tx_busy` falls in the cycle after the tenth strobe.
- R9: While `link_en` is 0, `host_ack`, both busy flags and `irq` stay 0. A frame in progress is abandoned. Ready requests and transmit triggers that arrive while disabled are forgotten.
- R10: A 0-to-1 change on `link_en` pulses `irq` for one cycle in the next cycle.
- R11: If no strobe arrives, `host_ack` stays high for exactly `wait_limit` cycles (for `wait_limit` ≥ 1). The link then returns to idle and clears `rx_busy`.
- R12: When a transmit trigger and a ready request are both pending, the transmission runs first. The remembered request starts a reception right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_en | input | 1 | Link enable (host clock enable) |
| wait_limit | input | TMO_W | Strobe wait limit in cycles |
| wr_en | input | 1 | Command write strobe |
| wr_pair | input | PAIR_W | Command register pair index |
| wr_be | input | 2 | Lane enables: [1] even nibble, [0] odd nibble |
| wr_data | input | 2*NIB_W | Write data, upper lane even nibble |
| rd_sel | input | SEL_W | Read select: 0..9 status, 10..19 command |
| rd_data | output | NIB_W | Selected register nibble |
| rx_busy | output | 1 | Status frame reception in progress |
| tx_busy | output | 1 | Command frame pending or being sent |
| irq | output | 1 | One-cycle interrupt pulse |
| drv_ready_n | input | 1 | Drive ready request, active low |
| drv_strobe | input | 1 | Drive strobe, one cycle per nibble |
| drv_din | input | NIB_W | Nibble from drive |
| drv_dout | output | NIB_W | Nibble to drive during transmission |
| host_ack | output | 1 | Host clock / acknowledge to drive |

## Verification
The bench goes after the interrupt position. A design that fires on the tenth nibble, or on both the eighth and the tenth, misses the eighth-nibble pulse or shows an extra one. It sweeps every pair and lane-enable combination, including the odd-only write of nibble 8. A trigger decode that looks at the pair alone would then start a spurious transmission. It also disables the link partway through a frame and while requests are pending. A design that keeps state across the disable would resume the handshake or raise interrupts afterward. Finally, it times out with the link idle and partway through a frame, and it raises a ready request and a trigger together. Off-by-one timers or a wrong arbitration order show up as a wrong acknowledge length or reception running first.

// File: rtl/nib_link_pkg.sv
// Shared types for the drive link host controller.
package nib_link_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX_ACK,
        ST_RX_GAP,
        ST_TX_ACK,
        ST_TX_GAP
    } link_state_t;
endpackage

// File: rtl/nib_link_cmd_regs.sv
// Command register file: NUM_NIB nibbles written as pairs under two lane
// enables (upper lane -> even nibble, lower lane -> odd nibble).
// Assumes NUM_NIB is even so the last nibble sits in the lower lane.
// Flags a send trigger whenever a write covers the last nibble.
module nib_link_cmd_regs #(
    parameter int NIB_W   = 4,
    parameter int NUM_NIB = 10,
    localparam int NUM_PAIR = NUM_NIB / 2,
    localparam int PAIR_W   = (NUM_PAIR > 1) ? $clog2(NUM_PAIR) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [PAIR_W-1:0]             wr_pair,
    input  logic [1:0]                    wr_be,
    input  logic [2*NIB_W-1:0]            wr_data,
    output logic [NUM_NIB-1:0][NIB_W-1:0] cmd_q,
    output logic                          send_trig
);
    localparam int LAST_PAIR = NUM_PAIR - 1;

    for (genvar g = 0; g < NUM_NIB; g++) begin : g_cmd
        localparam int PAIR = g / 2;
        localparam int LANE = (g % 2 == 0) ? 1 : 0;
        // Store one nibble when its pair and lane are addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cmd_q[g] <= '0;
            else if (wr_en && wr_pair == PAIR_W'(PAIR) && wr_be[LANE])
                cmd_q[g] <= wr_data[LANE*NIB_W +: NIB_W];
        end
    end

    // Launch a transmission only when the last nibble is written.
    assign send_trig = wr_en && wr_pair == PAIR_W'(LAST_PAIR) && wr_be[0];

    assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cmd_q));
endmodule

// File: rtl/nib_link_sts_regs.sv
// Status register file: filled one nibble at a time by the link sequencer.
// The host has no write path into it.
module nib_link_sts_regs #(
    parameter int NIB_W   = 4,
    parameter int NUM_NIB = 10,
    localparam int IDX_W  = $clog2(NUM_NIB)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rx_we,
    input  logic [IDX_W-1:0]              rx_idx,
    input  logic [NIB_W-1:0]              rx_nib,
    output logic [NUM_NIB-1:0][NIB_W-1:0] sts_q
);
    for (genvar g = 0; g < NUM_NIB; g++) begin : g_sts
        // Capture the received nibble into its slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sts_q[g] <= '0;
            else if (rx_we && rx_idx == IDX_W'(g))
                sts_q[g] <= rx_nib;
        end
    end

    assert_sts_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_we |=> $stable(sts_q));
endmodule

// File: rtl/nib_link_seq.sv
// Link sequencer: arbitrates between pending transmit and receive frames,
// runs the acknowledge/strobe handshake per nibble, times out waits,
// and produces the busy flags and interrupt pulse.
// Assumes drv_strobe and drv_ready_n are already synchronous to clk.
module nib_link_seq
    import nib_link_pkg::*;
#(
    parameter int NUM_NIB = 10,
    parameter int IRQ_NIB = 8,
    parameter int TMO_W   = 16,
    localparam int IDX_W  = $clog2(NUM_NIB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_en,
    input  logic [TMO_W-1:0] wait_limit,
    input  logic             drv_ready_n,
    input  logic             drv_strobe,
    input  logic             send_trig,
    output logic             host_ack,
    output logic             rx_we,
    output logic [IDX_W-1:0] idx,
    output logic             tx_active,
    output logic             rx_busy,
    output logic             tx_busy,
    output logic             irq
);
    link_state_t      state;
    logic [TMO_W-1:0] tmr;
    logic             ready_q, en_q, rx_req, tx_pend;
    logic             last_nib, timed_out, irq_nib;

    assign last_nib  = (idx == IDX_W'(NUM_NIB - 1));
    assign irq_nib   = (idx == IDX_W'(IRQ_NIB - 1));
    assign timed_out = !drv_strobe && (tmr == wait_limit - 1'b1);
    assign host_ack  = (state == ST_RX_ACK) || (state == ST_TX_ACK);
    assign tx_active = (state == ST_TX_ACK);
    assign rx_we     = link_en && (state == ST_RX_ACK) && drv_strobe;
    assign tx_busy   = tx_pend || (state == ST_TX_ACK) || (state == ST_TX_GAP);

    // Edge history of the ready request and the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b1;
            en_q    <= 1'b0;
        end else begin
            ready_q <= drv_ready_n;
            en_q    <= link_en;
        end
    end

    // Interrupt pulse: enable rising edge or eighth status nibble stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= (link_en && !en_q) || (rx_we && irq_nib);
    end

    // Handshake state machine with request latching and wait timer.
    always_ff @(posedge clk) begin
        if (!rst_n || !link_en) begin
            state   <= ST_IDLE;
            idx     <= '0;
            tmr     <= '0;
            rx_req  <= 1'b0;
            tx_pend <= 1'b0;
            rx_busy <= 1'b0;
        end else begin
            if (ready_q && !drv_ready_n) rx_req <= 1'b1;
            if (send_trig) tx_pend <= 1'b1;
            case (state)
                ST_IDLE: begin
                    idx <= '0;
                    tmr <= '0;
                    if (tx_pend) begin
                        tx_pend <= 1'b0;
                        state   <= ST_TX_ACK;
                    end else if (rx_req) begin
                        rx_req <= 1'b0;
                        state  <= ST_RX_ACK;
                    end
                end
                ST_RX_ACK: begin
                    if (drv_strobe) begin
                        tmr <= '0;
                        if (idx == '0) rx_busy <= 1'b1;
                        if (last_nib) begin
                            rx_busy <= 1'b0;
                            state   <= ST_IDLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= ST_RX_GAP;
                        end
                    end else if (timed_out) begin
                        tmr     <= '0;
                        rx_busy <= 1'b0;
                        state   <= ST_IDLE;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_TX_ACK: begin
                    if (drv_strobe) begin
                        tmr <= '0;
                        if (last_nib) state <= ST_IDLE;
                        else begin
                            idx   <= idx + 1'b1;
                            state <= ST_TX_GAP;
                        end
                    end else if (timed_out) begin
                        tmr   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_RX_GAP: state <= ST_RX_ACK;
                ST_TX_GAP: state <= ST_TX_ACK;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    assert_off_no_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |=> (!host_ack && !rx_busy && !tx_busy));
    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    assert_rx_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_we && last_nib) |=> !rx_busy);
    assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        idx < IDX_W'(NUM_NIB));
    assert_one_dir_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_busy && tx_active));
endmodule

// File: rtl/nib_link_host.sv
// Top of the drive link host controller: command and status register
// files, the handshake sequencer, the host read multiplexer and the
// outgoing nibble selection. Inputs from the drive are assumed synchronous.
module nib_link_host #(
    parameter int NIB_W   = 4,
    parameter int NUM_NIB = 10,
    parameter int IRQ_NIB = 8,
    parameter int TMO_W   = 16,
    localparam int NUM_PAIR = NUM_NIB / 2,
    localparam int PAIR_W   = (NUM_PAIR > 1) ? $clog2(NUM_PAIR) : 1,
    localparam int SEL_W    = $clog2(2 * NUM_NIB)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                link_en,
    input  logic [TMO_W-1:0]    wait_limit,
    input  logic                wr_en,
    input  logic [PAIR_W-1:0]   wr_pair,
    input  logic [1:0]          wr_be,
    input  logic [2*NIB_W-1:0]  wr_data,
    input  logic [SEL_W-1:0]    rd_sel,
    output logic [NIB_W-1:0]    rd_data,
    output logic                rx_busy,
    output logic                tx_busy,
    output logic                irq,
    input  logic                drv_ready_n,
    input  logic                drv_strobe,
    input  logic [NIB_W-1:0]    drv_din,
    output logic [NIB_W-1:0]    drv_dout,
    output logic                host_ack
);
    localparam int IDX_W = $clog2(NUM_NIB);

    logic [NUM_NIB-1:0][NIB_W-1:0] cmd_q, sts_q;
    logic                          send_trig, rx_we, tx_active;
    logic [IDX_W-1:0]              idx;

    nib_link_cmd_regs #(.NIB_W(NIB_W), .NUM_NIB(NUM_NIB)) i_cmd (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pair(wr_pair),
        .wr_be(wr_be), .wr_data(wr_data), .cmd_q(cmd_q), .send_trig(send_trig)
    );

    nib_link_sts_regs #(.NIB_W(NIB_W), .NUM_NIB(NUM_NIB)) i_sts (
        .clk(clk), .rst_n(rst_n), .rx_we(rx_we), .rx_idx(idx),
        .rx_nib(drv_din), .sts_q(sts_q)
    );

    nib_link_seq #(.NUM_NIB(NUM_NIB), .IRQ_NIB(IRQ_NIB), .TMO_W(TMO_W)) i_seq (
        .clk(clk), .rst_n(rst_n), .link_en(link_en), .wait_limit(wait_limit),
        .drv_ready_n(drv_ready_n), .drv_strobe(drv_strobe), .send_trig(send_trig),
        .host_ack(host_ack), .rx_we(rx_we), .idx(idx), .tx_active(tx_active),
        .rx_busy(rx_busy), .tx_busy(tx_busy), .irq(irq)
    );

    // Host read map: status first, command after it, zero elsewhere.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_NIB; i++) begin
            if (rd_sel == SEL_W'(i))           rd_data = sts_q[i];
            if (rd_sel == SEL_W'(NUM_NIB + i)) rd_data = cmd_q[i];
        end
    end

    // Present the current command nibble while transmitting.
    always_comb begin
        drv_dout = '0;
        for (int i = 0; i < NUM_NIB; i++)
            if (tx_active && idx == IDX_W'(i)) drv_dout = cmd_q[i];
    end

    assert_dout_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> drv_dout == '0);
endmodule

// File: tb/test_nib_link_host.sv
module test_nib_link_host;
    localparam int CLK_PERIOD = 10;
    localparam int N = 10;

    logic       clk = 0, rst_n = 0, link_en = 0;
    logic [15:0] wait_limit = 16'd1000;
    logic       wr_en = 0;
    logic [2:0] wr_pair = 0;
    logic [1:0] wr_be = 0;
    logic [7:0] wr_data = 0;
    logic [4:0] rd_sel = 0;
    logic [3:0] rd_data, drv_din = 0, drv_dout;
    logic       rx_busy, tx_busy, irq, host_ack;
    logic       drv_ready_n = 1, drv_strobe = 0;

    int checks = 0, fails = 0;
    logic [3:0] exp_cmd [N];

    nib_link_host i_nib_link_host (
        .clk(clk), .rst_n(rst_n), .link_en(link_en), .wait_limit(wait_limit),
        .wr_en(wr_en), .wr_pair(wr_pair), .wr_be(wr_be), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .rx_busy(rx_busy), .tx_busy(tx_busy),
        .irq(irq), .drv_ready_n(drv_ready_n), .drv_strobe(drv_strobe),
        .drv_din(drv_din), .drv_dout(drv_dout), .host_ack(host_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic rd(input int sel, output int val);
        rd_sel = 5'(sel);
        #1;
        val = int'(rd_data);
    endtask

    task automatic wr(input int pair, input int be, input int hi, input int lo);
        wr_en = 1; wr_pair = 3'(pair); wr_be = 2'(be);
        wr_data = {4'(hi), 4'(lo)};
        tick();
        wr_en = 0;
    endtask

    task automatic ready_pulse();
        drv_ready_n = 0;
        tick();
        drv_ready_n = 1;
    endtask

    task automatic wait_ack();
        for (int i = 0; i < 50 && !host_ack; i++) tick();
    endtask

    function automatic int rx_val(int f, int k);
        return (f * 7 + k * 3 + 1) % 16;
    endfunction

    // Receive one frame starting with host_ack high.
    task automatic rx_body(input int f);
        int v;
        for (int k = 0; k < N; k++) begin
            chk("R4 ack before nibble", host_ack, 1);
            chk("R5 busy before nibble", rx_busy, k > 0);
            drv_din = 4'(rx_val(f, k)); drv_strobe = 1;
            tick();
            drv_strobe = 0;
            chk("R6 irq after nibble", irq, k == 7);
            chk("R5 busy after nibble", rx_busy, k < N - 1);
            chk("R4 ack gap", host_ack, 0);
            rd(k, v);
            chk("R4 status nibble", v, rx_val(f, k));
            tick();
        end
        chk("R6 no irq after last", irq, 0);
        chk("R4 idle after frame", host_ack, 0);
    endtask

    // Transmit one frame starting with host_ack high.
    task automatic tx_body();
        for (int k = 0; k < N; k++) begin
            chk("R8 ack", host_ack, 1);
            chk("R8 dout", drv_dout, exp_cmd[k]);
            chk("R8 busy", tx_busy, 1);
            drv_strobe = 1;
            tick();
            drv_strobe = 0;
            chk("R8 ack gap", host_ack, 0);
            chk("R8 busy after", tx_busy, k < N - 1);
            tick();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int v, cnt, sts_snap [N];
        for (int i = 0; i < N; i++) exp_cmd[i] = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1 ack", host_ack, 0); chk("R1 rxb", rx_busy, 0);
        chk("R1 txb", tx_busy, 0);  chk("R1 irq", irq, 0);
        chk("R1 dout", drv_dout, 0);
        for (int s = 0; s < 2 * N; s++) begin rd(s, v); chk("R1 reg", v, 0); end

        // R3/R2 sweep while disabled (trigger discarded)
        for (int p = 0; p < 8; p++)
            for (int be = 0; be < 4; be++) begin
                int hi = (p * 3 + be + 1) % 16, lo = (p + be * 5 + 2) % 16;
                wr(p, be, hi, lo);
                if (p < 5 && be[1]) exp_cmd[2*p] = 4'(hi);
                if (p < 5 && be[0]) exp_cmd[2*p+1] = 4'(lo);
                for (int i = 0; i < N; i++) begin
                    rd(N + i, v); chk("R3 cmd readback", v, exp_cmd[i]);
                    rd(i, v);     chk("R2 status untouched", v, 0);
                end
                chk("R9 no tx while off", tx_busy, 0);
            end

        // R10 enable edge interrupt
        link_en = 1;
        tick(); chk("R10 irq pulse", irq, 1);
        tick(); chk("R10 irq one cycle", irq, 0);

        // R7 nibble 8 alone
        wr(4, 2, 9, 0); exp_cmd[8] = 9;
        for (int i = 0; i < 10; i++) begin
            chk("R7 no tx busy", tx_busy, 0); chk("R7 no ack", host_ack, 0); tick();
        end

        // R8 transmit after last nibble write
        wr(4, 1, 0, 6); exp_cmd[9] = 6;
        chk("R8 busy next cycle", tx_busy, 1);
        chk("R8 ack not yet", host_ack, 0);
        tick();
        tx_body();

        // R4/R5/R6 several frames with exact start timing
        for (int f = 0; f < 4; f++) begin
            ready_pulse();
            chk("R4 ack delay", host_ack, 0);
            tick();
            rx_body(f);
            repeat (2) tick();
        end

        // R11 timeout with no strobe
        wait_limit = 5;
        ready_pulse(); wait_ack();
        cnt = 0;
        while (host_ack && cnt < 100) begin cnt++; tick(); end
        chk("R11 ack length", cnt, 5);
        // R11 timeout mid frame
        ready_pulse(); wait_ack();
        for (int k = 0; k < 2; k++) begin
            drv_din = 4'(k + 3); drv_strobe = 1; tick(); drv_strobe = 0; tick();
        end
        chk("R11 busy mid frame", rx_busy, 1);
        cnt = 0;
        while (host_ack && cnt < 100) begin cnt++; tick(); end
        chk("R11 mid ack length", cnt, 5);
        chk("R11 busy cleared", rx_busy, 0);
        wait_limit = 1000;

        // R9 disable mid frame
        for (int i = 0; i < N; i++) begin rd(i, v); sts_snap[i] = v; end
        ready_pulse(); wait_ack();
        for (int k = 0; k < 3; k++) begin
            drv_din = 4'(k + 11); drv_strobe = 1; tick(); drv_strobe = 0; tick();
            sts_snap[k] = k + 11;
        end
        link_en = 0;
        tick();
        chk("R9 ack dropped", host_ack, 0); chk("R9 busy dropped", rx_busy, 0);
        ready_pulse();
        wr(4, 1, 0, 6);
        for (int i = 0; i < 15; i++) begin
            chk("R9 ack off", host_ack, 0); chk("R9 irq off", irq, 0);
            chk("R9 txb off", tx_busy, 0);
            drv_strobe = 1; tick(); drv_strobe = 0;
        end
        for (int i = 0; i < N; i++) begin rd(i, v); chk("R9 status kept", v, sts_snap[i]); end
        link_en = 1;
        tick(); chk("R10 irq re-enable", irq, 1);
        for (int i = 0; i < 10; i++) begin
            tick(); chk("R9 requests forgotten", host_ack, 0);
        end

        // R12 trigger and request together: transmit first
        drv_ready_n = 0; wr_en = 1; wr_pair = 4; wr_be = 1; wr_data = 8'h06;
        tick();
        wr_en = 0; drv_ready_n = 1;
        chk("R12 tx pending", tx_busy, 1);
        tick();
        chk("R12 tx first", host_ack, 1); chk("R12 rx idle", rx_busy, 0);
        tx_body();
        wait_ack();
        chk("R12 rx follows", host_ack, 1);
        rx_body(9);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule